// File: doc/BRIEF.md
# Context-Tagged Translation Lookaside Buffer

This block is a small, fully associative cache of 4 KiB page translations. It sits beside a page walker. A lookup presents a 36-bit virtual page number and a 12-bit page offset. In the same cycle the block reports a hit or a miss and, on a hit, a 40-bit physical address. The physical address is the cached 28-bit frame number with the offset appended unchanged. The walker installs translations through a one-cycle fill port.

Each entry holds a context tag, so translations from several address spaces can live side by side. The root-pointer write port carries the low 12 bits of the new root pointer and a tagging enable. With tagging on, those bits become the current context and the cached entries stay. With tagging off, the bits are ignored, the context becomes zero, and all non-global entries are dropped. Global entries hit in every context. A separate flush input empties the whole buffer.

Top module: `ctx_tlb`

## Requirements
- R1: After reset no entry is valid, the current context is 0 and the replacement pointer is 0, so every lookup misses.
- R2: A lookup hits when a valid entry has an equal page number and is either global or tagged with the current context. The result appears in the same cycle. On a miss, `lk_miss` is 1, `lk_hit` is 0 and `lk_paddr` is 0.
- R3: On a hit, `lk_paddr` equals {frame number of the hitting entry, `lk_off`}: the offset occupies bits 11:0 and the frame number occupies bits 39:12.
- R4: A non-global fill is tagged with the context current in the fill cycle. A global fill hits under any later context.
- R5: A root write with `root_tag_en`=1 sets the current context to `root_ctx_lo` and keeps every cached entry.
- R6: A root write with `root_tag_en`=0 sets the current context to 0, whatever `root_ctx_lo` holds. It invalidates every non-global entry and keeps the global ones.
- R7: A fill chooses its slot in this order. (a) It overwrites the lowest-numbered valid entry with the same page number whose tag conflicts, meaning either side is global or the contexts are equal, and it invalidates any other conflicting entry. (b) Otherwise it takes the lowest-numbered invalid entry. (c) Otherwise it takes the slot named by a round-robin pointer, which then advances by one modulo 16. Only case (c) moves the pointer.
- R8: `flush_all` invalidates every entry, global ones included, and a fill in the same cycle is discarded.
- R9: When a fill and a root write fall in the same cycle, the fill is tagged with the old context, and then the root write takes effect.
- R10: At most one entry hits on any lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vpn | input | 36 | Lookup virtual page number |
| lk_off | input | 12 | Lookup page offset |
| lk_hit | output | 1 | Lookup hit |
| lk_miss | output | 1 | Lookup miss |
| lk_paddr | output | 40 | Translated physical address (0 on miss) |
| fill_en | input | 1 | Install a translation this cycle |
| fill_vpn | input | 36 | Page number to install |
| fill_pfn | input | 28 | Frame number to install |
| fill_glb | input | 1 | Installed translation is global |
| root_wr | input | 1 | Root pointer write strobe |
| root_ctx_lo | input | 12 | Low 12 bits of the written root pointer |
| root_tag_en | input | 1 | Context tagging enable carried with the write |
| flush_all | input | 1 | Invalidate every entry |

## Verification
A lookup result is combinational, so the response to `lk_vpn` and `lk_off` is due within the same cycle. A fill, a root write or a flush is registered on the next rising edge, and its effect is seen by lookups in the cycle after that edge. The bench drives every input just after a falling edge and samples the lookup outputs 1 ns later, against a reference model holding the state built up to that edge. It then advances the model by the operations applied in that cycle, before the rising edge commits them in the design.

// File: rtl/ctx_tlb_pkg.sv
package ctx_tlb_pkg;
    localparam int VPN_W = 36;
    localparam int PFN_W = 28;
    localparam int CTX_W = 12;
    localparam int OFF_W = 12;

    typedef struct packed {
        logic             vld;
        logic             glb;
        logic [CTX_W-1:0] ctx;
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
    } tlb_entry_t;
endpackage

// File: rtl/tlb_cmp.sv
module tlb_cmp
    import ctx_tlb_pkg::*;
#(
    parameter int N = 16
) (
    input  tlb_entry_t [N-1:0] ents,
    input  logic [CTX_W-1:0]   cur_ctx,
    input  logic [VPN_W-1:0]   lk_vpn,
    input  logic [VPN_W-1:0]   fill_vpn,
    input  logic               fill_glb,
    output logic [N-1:0]       lk_hit_vec,
    output logic [N-1:0]       fill_hit_vec
);
    for (genvar g = 0; g < N; g++) begin : g_slot
        logic ctx_eq;
        assign ctx_eq          = (ents[g].ctx == cur_ctx);
        assign lk_hit_vec[g]   = ents[g].vld && (ents[g].vpn == lk_vpn)
                                 && (ents[g].glb || ctx_eq);
        assign fill_hit_vec[g] = ents[g].vld && (ents[g].vpn == fill_vpn)
                                 && (ents[g].glb || fill_glb || ctx_eq);
    end
endmodule

// File: rtl/tlb_slot_pick.sv
module tlb_slot_pick #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  valid_vec,
    input  logic [N-1:0]  match_vec,
    input  logic [IW-1:0] rr_q,
    output logic [IW-1:0] slot,
    output logic          use_rr,
    output logic [N-1:0]  extra_vec
);
    logic [IW-1:0] match_idx;
    logic [IW-1:0] free_idx;
    logic          any_free;

    always_comb begin
        match_idx = '0;
        free_idx  = '0;
        any_free  = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match_vec[i]) match_idx = IW'(i);
            if (!valid_vec[i]) begin
                free_idx = IW'(i);
                any_free = 1'b1;
            end
        end
        if (|match_vec) begin
            slot   = match_idx;
            use_rr = 1'b0;
        end else if (any_free) begin
            slot   = free_idx;
            use_rr = 1'b0;
        end else begin
            slot   = rr_q;
            use_rr = 1'b1;
        end
        extra_vec = match_vec;
        extra_vec[match_idx] = 1'b0;
    end
endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
    import ctx_tlb_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [VPN_W-1:0]         lk_vpn,
    input  logic [OFF_W-1:0]         lk_off,
    output logic                     lk_hit,
    output logic                     lk_miss,
    output logic [PFN_W+OFF_W-1:0]   lk_paddr,
    input  logic                     fill_en,
    input  logic [VPN_W-1:0]         fill_vpn,
    input  logic [PFN_W-1:0]         fill_pfn,
    input  logic                     fill_glb,
    input  logic                     root_wr,
    input  logic [CTX_W-1:0]         root_ctx_lo,
    input  logic                     root_tag_en,
    input  logic                     flush_all
);
    localparam int IDX_W = $clog2(ENTRIES);

    typedef struct packed {
        tlb_entry_t [ENTRIES-1:0] ent;
        logic [IDX_W-1:0]         rr;
        logic [CTX_W-1:0]         ctx;
    } tlb_state_t;

    tlb_state_t st_d, st_q;

    logic [ENTRIES-1:0] lk_hit_vec, fill_hit_vec, extra_vec, vld_vec, glb_vec;
    logic [IDX_W-1:0]   slot;
    logic               use_rr;
    logic [PFN_W-1:0]   lk_pfn;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_flags
        assign vld_vec[g] = st_q.ent[g].vld;
        assign glb_vec[g] = st_q.ent[g].glb;
    end

    tlb_cmp #(.N(ENTRIES)) u_cmp (
        .ents         (st_q.ent),
        .cur_ctx      (st_q.ctx),
        .lk_vpn       (lk_vpn),
        .fill_vpn     (fill_vpn),
        .fill_glb     (fill_glb),
        .lk_hit_vec   (lk_hit_vec),
        .fill_hit_vec (fill_hit_vec)
    );

    tlb_slot_pick #(.N(ENTRIES), .IW(IDX_W)) u_pick (
        .valid_vec (vld_vec),
        .match_vec (fill_hit_vec),
        .rr_q      (st_q.rr),
        .slot      (slot),
        .use_rr    (use_rr),
        .extra_vec (extra_vec)
    );

    always_comb begin
        lk_pfn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_hit_vec[i]) lk_pfn = lk_pfn | st_q.ent[i].pfn;
        end
    end

    assign lk_hit   = |lk_hit_vec;
    assign lk_miss  = ~lk_hit;
    assign lk_paddr = lk_hit ? {lk_pfn, lk_off} : '0;

    always_comb begin
        st_d = st_q;
        if (root_wr) begin
            st_d.ctx = root_tag_en ? root_ctx_lo : '0;
        end
        if (flush_all) begin
            for (int i = 0; i < ENTRIES; i++) st_d.ent[i].vld = 1'b0;
        end else begin
            if (fill_en) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (extra_vec[i]) st_d.ent[i].vld = 1'b0;
                end
                st_d.ent[slot].vld = 1'b1;
                st_d.ent[slot].glb = fill_glb;
                st_d.ent[slot].ctx = st_q.ctx;
                st_d.ent[slot].vpn = fill_vpn;
                st_d.ent[slot].pfn = fill_pfn;
                if (use_rr) begin
                    st_d.rr = (st_q.rr == IDX_W'(ENTRIES - 1)) ? '0 : st_q.rr + 1'b1;
                end
            end
            if (root_wr && !root_tag_en) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (!st_d.ent[i].glb) st_d.ent[i].vld = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R10
    single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_hit_vec));

    // R8
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> ($countones(vld_vec) == 0) && !lk_hit);

    // R7
    fill_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush_all && !root_wr) |=> ((lk_vpn != $past(fill_vpn)) || lk_hit));

    // R5
    keep_on_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (root_wr && root_tag_en && !fill_en && !flush_all) |=> $stable(vld_vec));

    // R6
    drop_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (root_wr && !root_tag_en && !flush_all) |=> ((vld_vec & ~glb_vec) == '0));
endmodule

// File: tb/ctx_tlb_test.sv
module ctx_tlb_test;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [35:0] lk_vpn = '0;
    logic [11:0] lk_off = '0;
    logic        lk_hit, lk_miss;
    logic [39:0] lk_paddr;
    logic        fill_en = 1'b0;
    logic [35:0] fill_vpn = '0;
    logic [27:0] fill_pfn = '0;
    logic        fill_glb = 1'b0;
    logic        root_wr = 1'b0;
    logic [11:0] root_ctx_lo = '0;
    logic        root_tag_en = 1'b0;
    logic        flush_all = 1'b0;

    int checks = 0;
    int errors = 0;

    // reference model
    bit          m_vld [N];
    bit          m_glb [N];
    logic [11:0] m_ctx [N];
    logic [35:0] m_vpn [N];
    logic [27:0] m_pfn [N];
    int          m_rr = 0;
    logic [11:0] m_cur = '0;

    always #2.5 clk = ~clk;

    ctx_tlb uut (
        .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_off(lk_off),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_glb(fill_glb),
        .root_wr(root_wr), .root_ctx_lo(root_ctx_lo), .root_tag_en(root_tag_en),
        .flush_all(flush_all)
    );

    function automatic logic [40:0] model_lookup(logic [35:0] v, logic [11:0] off);
        for (int i = 0; i < N; i++) begin
            if (m_vld[i] && m_vpn[i] == v && (m_glb[i] || m_ctx[i] == m_cur))
                return {1'b1, m_pfn[i], off};
        end
        return '0;
    endfunction

    task automatic model_step();
        if (flush_all) begin
            for (int i = 0; i < N; i++) m_vld[i] = 0;
        end else begin
            if (fill_en) begin
                int m = -1;
                for (int i = 0; i < N; i++) begin
                    if (m_vld[i] && m_vpn[i] == fill_vpn &&
                        (m_glb[i] || fill_glb || m_ctx[i] == m_cur)) begin
                        if (m < 0) m = i;
                        else m_vld[i] = 0;
                    end
                end
                if (m < 0) begin
                    for (int i = 0; i < N; i++) if (m < 0 && !m_vld[i]) m = i;
                end
                if (m < 0) begin
                    m = m_rr;
                    m_rr = (m_rr + 1) % N;
                end
                m_vld[m] = 1; m_glb[m] = fill_glb; m_ctx[m] = m_cur;
                m_vpn[m] = fill_vpn; m_pfn[m] = fill_pfn;
            end
            if (root_wr && !root_tag_en) begin
                for (int i = 0; i < N; i++) if (!m_glb[i]) m_vld[i] = 0;
            end
        end
        if (root_wr) m_cur = root_tag_en ? root_ctx_lo : 12'h0;
    endtask

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // one cycle: drive after negedge, compare lookup, advance model
    task automatic cyc(string tag, logic [35:0] lv, logic [11:0] lo,
                       bit fe, logic [35:0] fv, logic [27:0] fp, bit fg,
                       bit rw, logic [11:0] rc, bit te, bit fa);
        logic [40:0] e;
        @(negedge clk);
        lk_vpn = lv; lk_off = lo;
        fill_en = fe; fill_vpn = fv; fill_pfn = fp; fill_glb = fg;
        root_wr = rw; root_ctx_lo = rc; root_tag_en = te; flush_all = fa;
        #1;
        e = model_lookup(lv, lo);
        check(tag, {63'b0, lk_hit}, {63'b0, e[40]}, "R2 hit");
        check(tag, {63'b0, lk_miss}, {63'b0, ~e[40]}, "R2 miss");
        check(tag, {24'b0, lk_paddr}, {24'b0, e[39:0]}, "R3 paddr");
        model_step();
    endtask

    task automatic look(string tag, logic [35:0] v);
        cyc(tag, v, 12'h5A5, 0, '0, '0, 0, 0, '0, 0, 0);
    endtask

    task automatic fill(string tag, logic [35:0] v, logic [27:0] p, bit g);
        cyc(tag, '0, '0, 1, v, p, g, 0, '0, 0, 0);
    endtask

    task automatic root(string tag, logic [11:0] c, bit te);
        cyc(tag, '0, '0, 0, '0, '0, 0, 1, c, te, 0);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    localparam logic [35:0] A = 36'h0_00AB_C100;
    localparam logic [35:0] B = 36'h0_00AB_C200;
    localparam logic [35:0] G = 36'h0_00AB_C300;

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < N; i++) m_vld[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        lk_vpn = A; #1;
        check("R1", {63'b0, lk_hit}, 64'd0, "hit during reset");
        rst_n = 1'b1;
        // R1: empty after reset
        look("R1", A);
        look("R1", 36'h0);
        // R4 / R6: tagging off, low bits ignored -> context 0
        root("R6", 12'hABC, 0);
        fill("R4", A, 28'h1111111, 0);
        fill("R4", G, 28'h3333333, 1);
        look("R4", A);
        // R5: switch to context 5 keeps entries, A no longer visible
        root("R5", 12'h005, 1);
        look("R5", A);
        look("R4", G);
        fill("R4", A, 28'h2222222, 0);
        look("R4", A);
        root("R5", 12'h000, 1);
        look("R5", A);
        // R9: fill together with root write uses the old context
        cyc("R9", '0, '0, 1, B, 28'h4444444, 0, 1, 12'h007, 1, 0);
        look("R9", B);
        root("R9", 12'h000, 1);
        look("R9", B);
        // R6: tagging off drops non-global, keeps global
        root("R6", 12'h123, 0);
        look("R6", A);
        look("R6", B);
        look("R6", G);
        // R7: overwrite instead of duplicate, then fill to eviction
        fill("R7", G, 28'h5555555, 1);
        look("R7", G);
        for (int i = 0; i < N + 3; i++) fill("R7", 36'h100 + 36'(i), 28'(i + 16), 0);
        for (int i = 0; i < N + 3; i++) look("R7", 36'h100 + 36'(i));
        look("R7", G);
        // R8: flush wins over a fill in the same cycle
        fill("R8", A, 28'h6666666, 1);
        cyc("R8", '0, '0, 1, B, 28'h7777777, 1, 0, '0, 0, 1);
        look("R8", A);
        look("R8", B);
        // random mix (R2 R3 R4 R5 R6 R7 R9 R10)
        for (int k = 0; k < 4000; k++) begin
            logic [35:0] lv, fv;
            logic [11:0] ctxs [4];
            bit fe, rw, fa;
            ctxs[0] = 12'h000; ctxs[1] = 12'h001; ctxs[2] = 12'h002; ctxs[3] = 12'h800;
            lv = 36'h200 + 36'($urandom % 24);
            fv = 36'h200 + 36'($urandom % 24);
            fe = ($urandom % 100) < 40;
            rw = ($urandom % 100) < 8;
            fa = ($urandom % 1000) < 8;
            cyc("R2", lv, 12'($urandom), fe, fv, 28'($urandom), ($urandom % 100) < 15,
                rw, ctxs[$urandom % 4], ($urandom % 4) != 0, fa);
        end
        @(negedge clk);
        fill_en = 0; root_wr = 0; flush_all = 0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule